// File: doc/BRIEF.md
# Device-Sleep Timeout Controller

This block drives the device-sleep sideband line of one serial storage host port. While the port is awake it measures how long the link has been quiet, in units of a 1 ms tick. The quiet-time limit is a 10-bit millisecond count scaled by a zero-based 4-bit factor. When automatic entry is on and the link has been quiet for the whole limit, the line is raised. Software can also raise it directly with a request, whether or not automatic entry is on. A port whose platform lacks the sideband line never raises it.

Once raised, the line is held for a minimum number of milliseconds. A wake request, or automatic entry being switched off, that arrives inside this window is remembered and acted on when the window ends. After the line drops, the controller counts an exit window before it reports that out-of-band signalling may begin. The timeout inputs are sampled only when a count restarts, so software may rewrite them at any time without upsetting a count already running. The package carries the power-on values that the port's register should load: factor 15, limit 4 ms, hold 10 ms, exit 20 ms, line present, automatic entry off.

Top module: `dslp_ctrl`

## Requirements
- R1: After reset `devslp` is 0, `busy` is 0 and `oob_ready` is 1.
- R2: With `cfg_present`=1 and `cfg_aggr_en`=1, `devslp` rises one clock after the tick that brings the quiet time to `cfg_idle_ms`×(`cfg_mult`+1) ms, and not earlier. `cfg_mult` is zero-based: 0 means ×1 and 15 means ×16. A limit of 0 raises `devslp` within two clocks of a count restart.
- R3: A `link_active` pulse clears the quiet-time count, and the full limit is then counted again.
- R4: `cfg_idle_ms` and `cfg_mult` are sampled when a count restarts: after reset, on `link_active`, and while the port is not awake. A change during a running count has no effect on that count.
- R5: With `cfg_aggr_en`=0 the quiet time never raises `devslp`. A one-cycle `sw_sleep_req` with `cfg_present`=1 raises `devslp` at the next clock.
- R6: With `cfg_present`=0, `devslp` never rises, whether from quiet time or from `sw_sleep_req`.
- R7: `devslp` stays high for at least max(`cfg_min_hold`,1) ticks. A `wake_req` inside this window is latched, and `devslp` falls one clock after the tick that completes the window.
- R8: Once the hold window has ended, a `wake_req` drops `devslp` at the next clock.
- R9: A 1-to-0 change of `cfg_aggr_en` while `devslp` is high drops it. The drop comes at the next clock after the hold window, or when the window completes if the change falls inside it.
- R10: From the clock at which `devslp` falls, `oob_ready` is 0 until `cfg_exit_ms` ticks have passed. It rises one clock after the completing tick.
- R11: `busy` is 1 during the hold window and the exit window. It is 0 while awake and while asleep past the hold window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1ms | input | 1 | Single-cycle pulse once per millisecond |
| link_active | input | 1 | Link traffic seen this cycle |
| sw_sleep_req | input | 1 | Software request to enter device sleep |
| wake_req | input | 1 | Request to leave device sleep |
| cfg_mult | input | 4 | Zero-based quiet-time factor |
| cfg_idle_ms | input | 10 | Quiet-time base, ms |
| cfg_min_hold | input | 5 | Minimum assertion time, ms (0 treated as 1) |
| cfg_exit_ms | input | 8 | Exit window, ms |
| cfg_present | input | 1 | Platform wires the sideband line |
| cfg_aggr_en | input | 1 | Automatic entry on quiet time |
| devslp | output | 1 | Device-sleep sideband line |
| busy | output | 1 | Hold or exit window in progress |
| oob_ready | output | 1 | Link may start out-of-band signalling |

## Verification
A quiet-time counter that is off by one, or that misses a restart, shows up as `devslp` rising one tick early or late, or rising after a `link_active` pulse should have pushed it back. This appears within a few milliseconds of ticks. A lost latched wake shows up as `devslp` staying high past the tick that ends the hold window, visible one clock after that tick. A wrong state decode or a shortened exit window shows up as `oob_ready` rising during the exit count. These are checked on the clock that follows each deciding tick.

// File: rtl/dslp_pkg.sv
package dslp_pkg;

    typedef enum logic [1:0] {
        ST_AWAKE  = 2'd0,
        ST_HOLD   = 2'd1,
        ST_ASLEEP = 2'd2,
        ST_EXIT   = 2'd3
    } dslp_state_e;

    // Power-on values for the port register that feeds the cfg_* inputs
    localparam logic [3:0] DFLT_MULT     = 4'hF;
    localparam logic [9:0] DFLT_IDLE_MS  = 10'h004;
    localparam logic [4:0] DFLT_MIN_HOLD = 5'h0A;
    localparam logic [7:0] DFLT_EXIT_MS  = 8'h14;
    localparam logic       DFLT_PRESENT  = 1'b1;
    localparam logic       DFLT_AGGR_EN  = 1'b0;

endpackage

// File: rtl/dslp_ms_timer.sv
module dslp_ms_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         tick,
    input  logic [W-1:0] target,
    output logic         done
);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] tgt;
    } tmr_t;

    tmr_t cur_q, nxt_d;

    assign done = (cur_q.cnt >= cur_q.tgt);

    always_comb begin
        nxt_d = cur_q;
        if (start) begin
            nxt_d.cnt = '0;
            nxt_d.tgt = target;
        end else if (tick && !done) begin
            nxt_d.cnt = cur_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    AST_TMR_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cur_q.cnt == '0)); // R7

    AST_TMR_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && tick && !done) |=> (cur_q.cnt == $past(cur_q.cnt) + 1'b1)); // R10

endmodule

// File: rtl/dslp_idle_timer.sv
module dslp_idle_timer #(
    parameter int MULT_W = 4,
    parameter int IDLE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              tick,
    input  logic [MULT_W-1:0] cfg_mult,
    input  logic [IDLE_W-1:0] cfg_idle_ms,
    output logic              done
);

    localparam int LIM_W = IDLE_W + MULT_W;

    typedef struct packed {
        logic [LIM_W-1:0] cnt;
        logic [LIM_W-1:0] lim;
        logic             loaded;
    } idle_t;

    idle_t            cur_q, nxt_d;
    logic [LIM_W-1:0] lim_calc;
    logic             reload;

    // zero-based factor: limit = base * (factor + 1)
    assign lim_calc = LIM_W'(cfg_idle_ms) * (LIM_W'(cfg_mult) + LIM_W'(1));
    assign reload   = restart | ~cur_q.loaded;
    assign done     = cur_q.loaded && (cur_q.cnt == cur_q.lim);

    always_comb begin
        nxt_d = cur_q;
        if (reload) begin
            nxt_d.cnt    = '0;
            nxt_d.lim    = lim_calc;
            nxt_d.loaded = 1'b1;
        end else if (tick && (cur_q.cnt < cur_q.lim)) begin
            nxt_d.cnt = cur_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    AST_IDLE_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cur_q.cnt == '0 && cur_q.loaded)); // R3

    AST_IDLE_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.loaded |-> (cur_q.cnt <= cur_q.lim)); // R2

endmodule

// File: rtl/dslp_ctrl.sv
module dslp_ctrl
    import dslp_pkg::*;
#(
    parameter int MULT_W = 4,
    parameter int IDLE_W = 10,
    parameter int HOLD_W = 5,
    parameter int EXIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1ms,
    input  logic              link_active,
    input  logic              sw_sleep_req,
    input  logic              wake_req,
    input  logic [MULT_W-1:0] cfg_mult,
    input  logic [IDLE_W-1:0] cfg_idle_ms,
    input  logic [HOLD_W-1:0] cfg_min_hold,
    input  logic [EXIT_W-1:0] cfg_exit_ms,
    input  logic              cfg_present,
    input  logic              cfg_aggr_en,
    output logic              devslp,
    output logic              busy,
    output logic              oob_ready
);

    localparam int TMR_W = (HOLD_W > EXIT_W) ? HOLD_W : EXIT_W;

    typedef struct packed {
        dslp_state_e state;
        logic        pending;
        logic        aggr;
    } ctrl_t;

    ctrl_t             cur_q, nxt_d;
    logic              idle_done, idle_restart;
    logic              tmr_start, tmr_done;
    logic [TMR_W-1:0]  tmr_target, hold_ms, exit_ms;
    logic              aggr_fall, wake_evt, enter_sleep;

    assign hold_ms      = (cfg_min_hold == '0) ? TMR_W'(1) : TMR_W'(cfg_min_hold);
    assign exit_ms      = TMR_W'(cfg_exit_ms);
    assign aggr_fall    = cur_q.aggr & ~cfg_aggr_en;
    assign wake_evt     = wake_req | aggr_fall;
    assign enter_sleep  = cfg_present &
                          (sw_sleep_req | (cfg_aggr_en & idle_done & ~link_active));
    assign idle_restart = link_active | (cur_q.state != ST_AWAKE);

    dslp_idle_timer #(
        .MULT_W (MULT_W),
        .IDLE_W (IDLE_W)
    ) i_idle (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (idle_restart),
        .tick        (tick_1ms),
        .cfg_mult    (cfg_mult),
        .cfg_idle_ms (cfg_idle_ms),
        .done        (idle_done)
    );

    // one timer serves both the hold window and the exit window
    dslp_ms_timer #(
        .W (TMR_W)
    ) i_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tmr_start),
        .tick   (tick_1ms),
        .target (tmr_target),
        .done   (tmr_done)
    );

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.aggr = cfg_aggr_en;
        tmr_start  = 1'b0;
        tmr_target = hold_ms;
        unique case (cur_q.state)
            ST_AWAKE: begin
                if (enter_sleep) begin
                    nxt_d.state   = ST_HOLD;
                    nxt_d.pending = 1'b0;
                    tmr_start     = 1'b1;
                end
            end
            ST_HOLD: begin
                nxt_d.pending = cur_q.pending | wake_evt;
                if (tmr_done) begin
                    if (nxt_d.pending) begin
                        nxt_d.state = ST_EXIT;
                        tmr_start   = 1'b1;
                        tmr_target  = exit_ms;
                    end else begin
                        nxt_d.state = ST_ASLEEP;
                    end
                end
            end
            ST_ASLEEP: begin
                if (wake_evt) begin
                    nxt_d.state = ST_EXIT;
                    tmr_start   = 1'b1;
                    tmr_target  = exit_ms;
                end
            end
            ST_EXIT: begin
                nxt_d.pending = 1'b0;
                if (tmr_done) begin
                    nxt_d.state = ST_AWAKE;
                end
            end
            default: nxt_d.state = ST_AWAKE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{state: ST_AWAKE, pending: 1'b0, aggr: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign devslp    = (cur_q.state == ST_HOLD) || (cur_q.state == ST_ASLEEP);
    assign busy      = (cur_q.state == ST_HOLD) || (cur_q.state == ST_EXIT);
    assign oob_ready = (cur_q.state == ST_AWAKE);

    AST_ABSENT_NO_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_AWAKE && !cfg_present) |=> !devslp); // R6

    AST_HOLD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_HOLD && !tmr_done) |=> devslp); // R7

    AST_ENTRY_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(devslp) |-> $past(sw_sleep_req || idle_done)); // R5

    AST_FAST_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_ASLEEP && wake_req) |=> !devslp); // R8

    AST_EXIT_BLOCKS_OOB: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(devslp) |-> (!oob_ready && busy)); // R10

endmodule

// File: tb/test_dslp_ctrl.sv
`timescale 1ns/1ps
module test_dslp_ctrl;
    import dslp_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1ms = 1'b0, link_active = 1'b0, sw_sleep_req = 1'b0, wake_req = 1'b0;
    logic [3:0] cfg_mult;
    logic [9:0] cfg_idle_ms;
    logic [4:0] cfg_min_hold;
    logic [7:0] cfg_exit_ms;
    logic       cfg_present, cfg_aggr_en;
    logic       devslp, busy, oob_ready;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    dslp_ctrl i_dslp_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_1ms     (tick_1ms),
        .link_active  (link_active),
        .sw_sleep_req (sw_sleep_req),
        .wake_req     (wake_req),
        .cfg_mult     (cfg_mult),
        .cfg_idle_ms  (cfg_idle_ms),
        .cfg_min_hold (cfg_min_hold),
        .cfg_exit_ms  (cfg_exit_ms),
        .cfg_present  (cfg_present),
        .cfg_aggr_en  (cfg_aggr_en),
        .devslp       (devslp),
        .busy         (busy),
        .oob_ready    (oob_ready)
    );

    // row layout: {factor[3:0], base_ms[9:0], ticks[7:0], expected devslp}
    localparam logic [22:0] IDLE_VEC [8] = '{
        {4'd0,  10'd3, 8'd2,  1'b0},
        {4'd0,  10'd3, 8'd3,  1'b1},
        {4'd1,  10'd2, 8'd3,  1'b0},
        {4'd1,  10'd2, 8'd4,  1'b1},
        {4'd15, 10'd1, 8'd15, 1'b0},
        {4'd15, 10'd1, 8'd16, 1'b1},
        {4'd3,  10'd0, 8'd0,  1'b1},
        {4'd2,  10'd5, 8'd14, 1'b0}
    };

    task automatic check(input string tag, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cycles(3);
        rst_n = 1'b1;
        cycles(2);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_1ms = 1'b1;
            @(negedge clk) tick_1ms = 1'b0;
            cycles(1);
        end
    endtask

    task automatic pulse_sw();
        @(negedge clk) sw_sleep_req = 1'b1;
        @(negedge clk) sw_sleep_req = 1'b0;
    endtask

    task automatic pulse_wake();
        @(negedge clk) wake_req = 1'b1;
        @(negedge clk) wake_req = 1'b0;
    endtask

    task automatic pulse_act();
        @(negedge clk) link_active = 1'b1;
        @(negedge clk) link_active = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        cfg_mult     = DFLT_MULT;
        cfg_idle_ms  = DFLT_IDLE_MS;
        cfg_min_hold = DFLT_MIN_HOLD;
        cfg_exit_ms  = DFLT_EXIT_MS;
        cfg_present  = DFLT_PRESENT;
        cfg_aggr_en  = DFLT_AGGR_EN;
        do_reset();
        check("R1 devslp", devslp, 1'b0);
        check("R1 busy", busy, 1'b0);
        check("R1 oob_ready", oob_ready, 1'b1);

        // R2: quiet-time limit table
        for (int r = 0; r < 8; r++) begin
            logic [22:0] row;
            row = IDLE_VEC[r];
            cfg_mult     = row[22:19];
            cfg_idle_ms  = row[18:9];
            cfg_min_hold = 5'd1;
            cfg_present  = 1'b1;
            cfg_aggr_en  = 1'b1;
            do_reset();
            ticks(int'(row[8:1]));
            cycles(1);
            check($sformatf("R2 row %0d", r), devslp, row[0]);
        end

        // R3: activity restarts the count
        cfg_mult = 4'd0; cfg_idle_ms = 10'd4; cfg_aggr_en = 1'b1;
        do_reset();
        ticks(3);
        pulse_act();
        ticks(3);
        check("R3 not yet after restart", devslp, 1'b0);
        ticks(1);
        check("R3 after full limit", devslp, 1'b1);

        // R4: base change mid-count ignored
        cfg_idle_ms = 10'd2;
        do_reset();
        ticks(1);
        cfg_idle_ms = 10'd50;
        ticks(1);
        check("R4 old limit kept", devslp, 1'b1);

        // R5: no quiet-time entry without automatic mode; software entry works
        cfg_idle_ms = 10'd2; cfg_aggr_en = 1'b0;
        do_reset();
        ticks(5);
        check("R5 no idle entry", devslp, 1'b0);
        pulse_sw();
        check("R5 sw entry", devslp, 1'b1);

        // R6: line absent
        cfg_present = 1'b0; cfg_aggr_en = 1'b1;
        do_reset();
        ticks(4);
        pulse_sw();
        cycles(2);
        check("R6 absent never asserts", devslp, 1'b0);
        cfg_present = 1'b1;

        // R7: hold window with latched wake
        cfg_aggr_en = 1'b0; cfg_min_hold = 5'd3; cfg_exit_ms = 8'd2;
        do_reset();
        pulse_sw();
        pulse_wake();
        ticks(2);
        check("R7 held during window", devslp, 1'b1);
        ticks(1);
        check("R7 released after window", devslp, 1'b0);

        // R7: zero hold treated as one tick
        cfg_min_hold = 5'd0;
        do_reset();
        pulse_sw();
        pulse_wake();
        cycles(3);
        check("R7 zero hold still held", devslp, 1'b1);
        ticks(1);
        check("R7 zero hold one tick", devslp, 1'b0);

        // R8, R10, R11: asleep, wake, exit window
        cfg_min_hold = 5'd1; cfg_exit_ms = 8'd2;
        do_reset();
        pulse_sw();
        check("R11 busy in hold", busy, 1'b1);
        ticks(1);
        check("R11 not busy asleep", busy, 1'b0);
        check("R11 still asleep", devslp, 1'b1);
        pulse_wake();
        check("R8 wake drops line", devslp, 1'b0);
        check("R10 oob blocked", oob_ready, 1'b0);
        check("R11 busy in exit", busy, 1'b1);
        ticks(1);
        check("R10 oob blocked mid window", oob_ready, 1'b0);
        ticks(1);
        check("R10 oob after window", oob_ready, 1'b1);
        check("R11 not busy awake", busy, 1'b0);

        // R9: automatic entry cleared while asleep
        cfg_idle_ms = 10'd1; cfg_mult = 4'd0; cfg_aggr_en = 1'b1; cfg_min_hold = 5'd1;
        do_reset();
        ticks(1);
        check("R9 entered", devslp, 1'b1);
        ticks(1);
        @(negedge clk) cfg_aggr_en = 1'b0;
        cycles(2);
        check("R9 clear drops line", devslp, 1'b0);

        // R9: clear inside hold window is latched
        cfg_aggr_en = 1'b1; cfg_min_hold = 5'd3;
        do_reset();
        ticks(1);
        @(negedge clk) cfg_aggr_en = 1'b0;
        ticks(2);
        check("R9 held while in window", devslp, 1'b1);
        ticks(1);
        check("R9 dropped at window end", devslp, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule